// File: doc/BRIEF.md
# Banked Register File with Working-Set Exchange

This block holds sixteen 16-bit general registers for a small processor core. Entry 0 is wired to zero. Entries 4 to 11 are the argument and temporary working set, and each of them has a second, alternate copy. All other entries have one copy that both banks share. These are the return address (1), stack pointer (2), global pointer (3) and callee-saved registers (12 to 15).

Two combinational read ports and one synchronous write port always see the bank that is currently selected. A one-cycle exchange strobe flips a single bank-select bit, and no data moves. An interrupt handler can therefore take a fresh working set in one cycle and return to the interrupted one with a second strobe. The ports carry plain control and data with no handshake: a register file accepts a write and answers a read in every cycle, so it never applies back-pressure.

Top module: `shadow_regfile`

## Requirements
- R1: After reset, every entry in both banks reads 0 and `bank_alt` is 0, which selects the primary bank.
- R2: Address 0 always reads 0 on both ports, and a write to address 0 has no effect.
- R3: A write with `wr_en`=1 becomes visible on the read ports from the cycle after the clock edge. A read of the same address in the cycle of the write returns the old value.
- R4: Each cycle with `xchg`=1 toggles `bank_alt` at the clock edge, so addresses 4 to 11 then show the other copy. A second strobe restores the first copy unchanged.
- R5: Addresses 1 to 3 and 12 to 15 return the same content whichever bank is selected, and an exchange does not alter them.
- R6: When a write and an exchange occur in the same cycle, the write lands in the bank that was selected before the toggle.
- R7: The two read ports decode their addresses independently and may read any pair of entries, including the same entry, in the same cycle.
- R8: A write to an address from 4 to 11 changes only the copy in the selected bank. The other copy keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 4 | Read port A address |
| rd_a_data | output | 16 | Read port A data, combinational |
| rd_b_addr | input | 4 | Read port B address |
| rd_b_data | output | 16 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| xchg | input | 1 | One-cycle exchange strobe |
| bank_alt | output | 1 | Current bank select: 1 when the alternate working set is selected |

## Verification
The bench builds the block with its default parameters: 16 entries of 16 bits, with entries 4 to 11 banked. With these values, every boundary of the banked window is reachable, because entries 3, 4, 11 and 12 sit on either side of it. Directed sequences cover reset, zero-register writes, same-cycle read-during-write, exchange round trips and a write in the same cycle as an exchange. A long pseudo-random phase then mixes writes, exchanges and dual reads, and compares every port against a behavioural model after each cycle.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // True when an entry index lies inside the banked working-set window.
  function automatic logic in_window(input int idx, input int first, input int last);
    return (idx >= first) && (idx <= last);
  endfunction

endpackage

// File: rtl/rf_bank_ctl.sv
module rf_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic xchg,
  output logic bank_q
);
  // The exchange only flips the selector; register contents never move.
  always_ff @(posedge clk) begin
    if (!rst_n) bank_q <= 1'b0;
    else if (xchg) bank_q <= ~bank_q;
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 16,
  parameter int BANK_FIRST = 4,
  parameter int BANK_LAST  = 11,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bank_q,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    view
);
  import regfile_pkg::*;

  logic [NUM_REGS-1:0] hit;

  always_comb begin
    hit = '0;
    if (wr_en) hit[wr_addr] = 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign view[i] = '0;
    end else if (in_window(i, BANK_FIRST, BANK_LAST)) begin : g_banked
      logic [DATA_W-1:0] pri_q;
      logic [DATA_W-1:0] alt_q;
      // bank_q is the pre-toggle value at this edge, so a write in the
      // same cycle as an exchange goes to the old bank.
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pri_q <= '0;
          alt_q <= '0;
        end else if (hit[i]) begin
          if (bank_q) alt_q <= wr_data;
          else        pri_q <= wr_data;
        end
      end
      assign view[i] = bank_q ? alt_q : pri_q;
    end else begin : g_shared
      logic [DATA_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (hit[i]) val_q <= wr_data;
      end
      assign view[i] = val_q;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] view,
  input  logic [ADDR_W-1:0]               addr,
  output logic [DATA_W-1:0]               data
);
  assign data = view[addr];
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 16,
  parameter int BANK_FIRST = 4,
  parameter int BANK_LAST  = 11,
  localparam int ADDR_W    = $clog2(NUM_REGS),
  localparam int NUM_RD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xchg,
  output logic              bank_alt
);
  logic                            bank_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] view;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  rf_bank_ctl u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .xchg   (xchg),
    .bank_q (bank_q)
  );

  rf_store #(
    .DATA_W     (DATA_W),
    .NUM_REGS   (NUM_REGS),
    .BANK_FIRST (BANK_FIRST),
    .BANK_LAST  (BANK_LAST)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank_q  (bank_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .view    (view)
  );

  assign rd_addr[0] = rd_a_addr;
  assign rd_addr[1] = rd_b_addr;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
    ) u_port (
      .view (view),
      .addr (rd_addr[p]),
      .data (rd_data[p])
    );
  end

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign bank_alt  = bank_q;
endmodule

// File: rtl/shadow_regfile_chk.sv
module shadow_regfile_chk #(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 16,
  parameter int BANK_FIRST = 4,
  parameter int BANK_LAST  = 11,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              xchg,
  input logic              bank_alt
);
  import regfile_pkg::*;

  // Set one cycle after reset is released, so that $past never reaches back into reset.
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic a_shared;
  assign a_shared = !in_window(int'(rd_a_addr), BANK_FIRST, BANK_LAST);

  AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0)); // R2
  AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == '0) |-> (rd_b_data == '0)); // R2
  AST_XCHG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && xchg) |=> (bank_alt != $past(bank_alt))); // R4
  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !xchg) |=> $stable(bank_alt)); // R4
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en) && ($past(wr_addr) != '0) && (rd_a_addr == $past(wr_addr))
      && (!$past(xchg) || a_shared))
    |-> (rd_a_data == $past(wr_data))); // R3
  AST_SHARED_SURVIVES_XCHG: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(xchg) && !$past(wr_en) && a_shared && (rd_a_addr == $past(rd_a_addr)))
    |-> (rd_a_data == $past(rd_a_data))); // R5
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data)); // R7
endmodule

bind shadow_regfile shadow_regfile_chk #(
  .DATA_W     (DATA_W),
  .NUM_REGS   (NUM_REGS),
  .BANK_FIRST (BANK_FIRST),
  .BANK_LAST  (BANK_LAST)
) u_chk (.*);

// File: tb/tb_shadow_regfile.sv
`timescale 1ns/1ps
module tb_shadow_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, xchg = 1'b0, bank_alt;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  shadow_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xchg(xchg), .bank_alt(bank_alt)
  );

  // Behavioural reference: one array per bank, shared entries kept in m_pri.
  logic [15:0] m_pri [16];
  logic [15:0] m_alt [16];
  logic        m_bank;

  function automatic logic banked(input int a);
    return a >= 4 && a <= 11;
  endfunction

  function automatic logic [15:0] m_read(input int a);
    if (a == 0) return 16'h0;
    if (banked(a) && m_bank) return m_alt[a];
    return m_pri[a];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_pri[i] = '0;
      m_alt[i] = '0;
    end
    m_bank = 1'b0;
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge, update the model after it.
  task automatic step(input string tag, input logic we, input int wa, input logic [15:0] wd,
                      input logic x, input int ra, input int rb);
    @(negedge clk);
    wr_en = we; wr_addr = 4'(wa); wr_data = wd; xchg = x;
    rd_a_addr = 4'(ra); rd_b_addr = 4'(rb);
    #1;
    chk({tag, " portA"}, rd_a_data, m_read(ra));
    chk({tag, " portB"}, rd_b_data, m_read(rb));
    chk({tag, " bank"}, {15'b0, bank_alt}, {15'b0, m_bank});
    @(posedge clk);
    if (we && wa != 0) begin
      if (banked(wa) && m_bank) m_alt[wa] = wd;
      else m_pri[wa] = wd;
    end
    if (x) m_bank = ~m_bank;
  endtask

  task automatic idle_read(input string tag, input int ra, input int rb);
    step(tag, 1'b0, 0, 16'h0, 1'b0, ra, rb);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    // Write attempts during reset must be ignored.
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 16'hDEAD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;

    // R1: reset state in the primary bank, then in the alternate bank.
    for (int i = 0; i < 16; i++) idle_read("R1 reset primary", i, 15 - i);
    step("R1 swap", 1'b0, 0, 16'h0, 1'b1, 0, 0);
    for (int i = 4; i < 12; i++) idle_read("R1 reset alternate", i, i);
    step("R1 swap back", 1'b0, 0, 16'h0, 1'b1, 0, 0);

    // R2: a write to the zero register is discarded.
    step("R2 write zero", 1'b1, 0, 16'hFFFF, 1'b0, 0, 0);
    idle_read("R2 zero stays", 0, 0);
    chk("R2 literal", rd_a_data, 16'h0);

    // R3: a same-cycle read returns the old value, and the new value appears one edge later.
    step("R3 write r5", 1'b1, 5, 16'h1111, 1'b0, 5, 5);
    chk("R3 old value", rd_a_data, 16'h0000);
    idle_read("R3 new value", 5, 1);
    chk("R3 literal", rd_a_data, 16'h1111);

    // R4 and R8: exchange, write the alternate copy, then return to the primary copy.
    step("R4 exchange", 1'b0, 0, 16'h0, 1'b1, 5, 5);
    idle_read("R4 alternate r5", 5, 4);
    chk("R4 alt literal", rd_a_data, 16'h0000);
    step("R8 write alt r5", 1'b1, 5, 16'h2222, 1'b0, 5, 5);
    step("R4 exchange back", 1'b0, 0, 16'h0, 1'b1, 5, 5);
    idle_read("R8 primary kept", 5, 5);
    chk("R8 literal", rd_a_data, 16'h1111);

    // R5: the shared entries on both sides of the window survive an exchange.
    step("R5 write r2", 1'b1, 2, 16'hABCD, 1'b0, 2, 3);
    step("R5 write r3", 1'b1, 3, 16'h3333, 1'b0, 2, 3);
    step("R5 write r12", 1'b1, 12, 16'hC0DE, 1'b0, 2, 12);
    step("R5 write r4", 1'b1, 4, 16'h4444, 1'b0, 4, 11);
    step("R5 write r11", 1'b1, 11, 16'hBBBB, 1'b0, 4, 11);
    step("R5 exchange", 1'b0, 0, 16'h0, 1'b1, 2, 12);
    idle_read("R5 shared after xchg", 2, 12);
    chk("R5 literal r2", rd_a_data, 16'hABCD);
    chk("R5 literal r12", rd_b_data, 16'hC0DE);
    idle_read("R5 window edges alt", 4, 11);
    idle_read("R5 window edges shared", 3, 12);

    // R6: a write in the same cycle as an exchange goes to the bank selected before the toggle (alternate here).
    step("R6 write+xchg", 1'b1, 6, 16'h6666, 1'b1, 6, 6);
    idle_read("R6 primary untouched", 6, 6);
    chk("R6 primary literal", rd_a_data, 16'h0000);
    step("R6 exchange", 1'b0, 0, 16'h0, 1'b1, 6, 6);
    idle_read("R6 alternate got write", 6, 6);
    chk("R6 alt literal", rd_a_data, 16'h6666);

    // R7: the two ports read different entries in the same cycle.
    idle_read("R7 dual read", 2, 6);
    chk("R7 literal A", rd_a_data, 16'hABCD);
    chk("R7 literal B", rd_b_data, 16'h6666);

    // Random mix of writes, exchanges and reads across R3 to R8.
    for (int n = 0; n < 3000; n++) begin
      lfsr = nxt(lfsr);
      step("R3-mix", lfsr[0] | lfsr[1], int'(lfsr[5:2]), {lfsr[7:0], lfsr[15:8]},
           (lfsr[10:8] == 3'd0), int'(lfsr[14:11]), int'(lfsr[9:6]));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule